// File: doc/BRIEF.md
# Absorber/Scatter Coincidence Selector

This block decides, cycle by cycle, whether a pair of detector triggers forms a usable Compton event. It watches one trigger line from the absorbing detector and nineteen trigger lines from the scattering detector's channels. An absorber trigger opens a drift window. The candidate survives only if exactly one scatter channel fires during that window. A quiet window follows, and any further trigger on any line during it throws the candidate away.

If the quiet window passes untouched, the block emits a one-cycle accept pulse. With it come the index of the scatter channel that fired and a time stamp taken from a free-running cycle counter. A disturbed quiet window instead produces a one-cycle purge pulse. The readout logic downstream uses these to fetch or drop the channel results. Both window lengths are counts of clock cycles supplied on input ports.

Top module: `coinc_select`

## Requirements
- R1: While reset (active low) is held and just after it, accept and purge are 0, and hit_addr and hit_stamp are 0.
- R2: In the idle state, scatter triggers on their own produce no output and do not start a candidate; only an absorber trigger starts one.
- R3: Let D be max(drift_len,1). Absorber trigger presented in cycle c: the drift window is cycles c through c+D inclusive. Scatter triggers in those cycles are counted. Absorber triggers inside the window have no effect.
- R4: If no scatter trigger falls in the drift window, the block returns silently to idle with no accept and no purge.
- R5: Two or more scatter hits in the drift window return the block silently to idle. This includes several channels in the same cycle and one channel firing twice.
- R6: Let I be max(integ_len,1). With exactly one hit, cycles c+D+1 through c+D+I form the quiet window. A trigger on any line in cycle q of that window gives a one-cycle purge pulse visible two cycles after q, and no accept.
- R7: If the quiet window is free of triggers, a one-cycle accept pulse is visible in cycle c+D+I+2. hit_addr then holds the index i of the channel that fired, where bit i of scat_trig is channel i.
- R8: A cycle counter starts at 0 after reset and increments every cycle. On accept, hit_stamp equals the counter value one cycle after the absorber trigger's cycle, modulo 2^TS_W.
- R9: accept and purge are never high together. hit_addr and hit_stamp change only on an accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abs_trig | input | 1 | Absorber detector trigger |
| scat_trig | input | N_SCAT (19) | Scatter channel triggers, bit i is channel i |
| drift_len | input | CNT_W (12) | Drift window length in cycles (0 acts as 1) |
| integ_len | input | CNT_W (12) | Quiet window length in cycles (0 acts as 1) |
| accept | output | 1 | One-cycle pulse: event accepted |
| purge | output | 1 | One-cycle pulse: candidate discarded |
| hit_addr | output | ADDR_W (5) | Index of the accepted scatter channel |
| hit_stamp | output | TS_W (16) | Time stamp of the accepted event |

## Verification
The assertions check several properties on every cycle. The two pulses never coincide, and an accept lasts one cycle. An accept only follows a quiet-window cycle that saw no trigger, and every purge is preceded by a trigger. A candidate in the quiet window always carries exactly one hit. Only the bench's scenarios can show the rest: the exact cycle at which a pulse appears for given window lengths, the clamping of zero lengths, silent rejection at zero and multiple hits, absorber triggers being ignored inside the drift window, and the reported channel index and time stamp.

// File: rtl/coinc_select.sv
module coinc_select #(
  parameter int N_SCAT = 19,
  parameter int CNT_W  = 12,
  parameter int TS_W   = 16,
  localparam int ADDR_W = $clog2(N_SCAT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abs_trig,
  input  logic [N_SCAT-1:0] scat_trig,
  input  logic [CNT_W-1:0]  drift_len,
  input  logic [CNT_W-1:0]  integ_len,
  output logic              accept,
  output logic              purge,
  output logic [ADDR_W-1:0] hit_addr,
  output logic [TS_W-1:0]   hit_stamp
);

  typedef enum logic [1:0] {S_IDLE, S_DRIFT, S_QUIET} st_t;

  st_t               st;
  logic              abs_q;
  logic [N_SCAT-1:0] scat_q;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        hits;
  logic [ADDR_W-1:0] cand_addr, enc;
  logic [TS_W-1:0]   ts, cand_stamp;

  logic [1:0] now_n;
  logic [2:0] hsum;
  logic       any_trig, drift_last, integ_last;

  assign now_n      = (scat_q == '0) ? 2'd0 : ($onehot(scat_q) ? 2'd1 : 2'd2);
  assign hsum       = {1'b0, hits} + {1'b0, now_n};
  assign any_trig   = abs_q | (|scat_q);
  assign drift_last = ({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, drift_len};
  assign integ_last = ({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, integ_len};

  always_comb begin
    enc = '0;
    for (int k = N_SCAT - 1; k >= 0; k--)
      if (scat_q[k]) enc = ADDR_W'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      abs_q      <= 1'b0;
      scat_q     <= '0;
      cnt        <= '0;
      hits       <= '0;
      cand_addr  <= '0;
      cand_stamp <= '0;
      ts         <= '0;
      accept     <= 1'b0;
      purge      <= 1'b0;
      hit_addr   <= '0;
      hit_stamp  <= '0;
    end else begin
      abs_q  <= abs_trig;
      scat_q <= scat_trig;
      ts     <= ts + TS_W'(1);
      accept <= 1'b0;
      purge  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (abs_q && now_n < 2'd2) begin
            st         <= S_DRIFT;
            cnt        <= '0;
            hits       <= now_n;
            cand_addr  <= enc;
            cand_stamp <= ts;
          end
        end
        S_DRIFT: begin
          if (hsum > 3'd1) begin
            st <= S_IDLE;
          end else begin
            hits <= hsum[1:0];
            if (now_n == 2'd1) cand_addr <= enc;
            if (drift_last) begin
              cnt <= '0;
              st  <= (hsum == 3'd1) ? S_QUIET : S_IDLE;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        S_QUIET: begin
          if (any_trig) begin
            purge <= 1'b1;
            st    <= S_IDLE;
          end else if (integ_last) begin
            accept    <= 1'b1;
            hit_addr  <= cand_addr;
            hit_stamp <= cand_stamp;
            st        <= S_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_NO_BOTH_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && purge)); // R9
  AST_ACCEPT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept); // R9
  AST_PURGE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    purge |-> $past(abs_q || (|scat_q))); // R6
  AST_ACCEPT_QUIET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(!abs_q && scat_q == '0)); // R7
  AST_ACCEPT_FROM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(st == S_QUIET)); // R7
  AST_QUIET_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_QUIET |-> hits == 2'd1); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !abs_q) |=> st == S_IDLE); // R2
  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> hit_addr < ADDR_W'(N_SCAT)); // R7

endmodule

// File: tb/coinc_select_test.sv
module coinc_select_test;
  localparam int N = 19;
  localparam int CW = 12;
  localparam int TW = 16;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          abs_trig = 1'b0;
  logic [N-1:0]  scat_trig = '0;
  logic [CW-1:0] drift_len = '0;
  logic [CW-1:0] integ_len = '0;
  logic          accept, purge;
  logic [AW-1:0] hit_addr;
  logic [TW-1:0] hit_stamp;

  coinc_select #(.N_SCAT(N), .CNT_W(CW), .TS_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .abs_trig(abs_trig), .scat_trig(scat_trig),
    .drift_len(drift_len), .integ_len(integ_len), .accept(accept),
    .purge(purge), .hit_addr(hit_addr), .hit_stamp(hit_stamp));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  int acc_n = 0, pur_n = 0, acc_cyc = 0, pur_cyc = 0, both_n = 0;
  always @(negedge clk) begin
    if (accept) begin acc_n++; acc_cyc = cyc; end
    if (purge) begin pur_n++; pur_cyc = cyc; end
    if (accept && purge) both_n++;
  end

  logic [N-1:0] sv [40];
  logic         av [40];
  int last_addr = 0, last_stamp = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_arr();
    for (int j = 0; j < 40; j++) begin sv[j] = '0; av[j] = 1'b0; end
  endtask

  task automatic run_ev(input int d, input int i, input string tag);
    int dd, ii, len, x, total, addr, kind, at;
    dd = (d < 1) ? 1 : d;
    ii = (i < 1) ? 1 : i;
    len = dd + ii + 2;
    drift_len = CW'(d);
    integ_len = CW'(i);
    acc_n = 0; pur_n = 0; both_n = 0;
    x = 0;
    for (int j = 0; j < len; j++) begin
      @(negedge clk);
      if (j == 0) x = cyc;
      abs_trig = av[j];
      scat_trig = sv[j];
    end
    @(negedge clk);
    abs_trig = 1'b0;
    scat_trig = '0;
    repeat (5) @(negedge clk);
    total = 0; addr = 0;
    for (int j = 0; j <= dd; j++) begin
      total += $countones(sv[j]);
      for (int k = 0; k < N; k++) if (sv[j][k]) addr = k;
    end
    kind = 0; at = 0;
    if (total == 1) begin
      kind = 1; at = x + dd + ii + 2;
      for (int j = ii + dd; j > dd; j--)
        if (av[j] || sv[j] != '0) begin kind = 2; at = x + j + 2; end
    end
    chk(both_n == 0, "R9 no simultaneous pulses", both_n, 0);
    if (kind == 0) begin
      chk(acc_n == 0 && pur_n == 0, tag, acc_n + pur_n, 0);
      chk(hit_addr == AW'(last_addr), "R9 addr held", hit_addr, last_addr);
    end else if (kind == 2) begin
      chk(pur_n == 1 && acc_n == 0, "R6 purge count", pur_n * 10 + acc_n, 10);
      chk(pur_cyc == at, "R6 purge timing", pur_cyc, at);
      chk(hit_stamp == TW'(last_stamp), "R9 stamp held", hit_stamp, last_stamp);
    end else begin
      chk(acc_n == 1 && pur_n == 0, "R7 accept count", acc_n * 10 + pur_n, 10);
      chk(acc_cyc == at, "R7 accept timing", acc_cyc, at);
      chk(hit_addr == AW'(addr), "R7 channel index", hit_addr, addr);
      chk(hit_stamp == TW'(x + 1), "R8 time stamp", hit_stamp, (x + 1) % (1 << TW));
      last_addr = addr;
      last_stamp = (x + 1) % (1 << TW);
    end
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired R1 actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(accept == 0 && purge == 0, "R1 pulses in reset", {accept, purge}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(accept == 0 && purge == 0 && hit_addr == 0 && hit_stamp == 0,
        "R1 state after reset", {accept, purge, hit_addr, hit_stamp}, 0);

    // R2: scatter triggers alone do nothing
    clear_arr();
    av[0] = 1'b0; sv[0] = 19'h00010; sv[2] = 19'h40001; sv[3] = 19'h00100;
    run_ev(3, 3, "R2 idle ignores scatter");
    // R3: hit in same cycle as absorber
    clear_arr(); av[0] = 1'b1; sv[0][7] = 1'b1;
    run_ev(3, 2, "R3 same-cycle hit");
    // R3: hit on last drift cycle, channel 18
    clear_arr(); av[0] = 1'b1; sv[4][18] = 1'b1;
    run_ev(4, 3, "R3 last drift cycle");
    // R4: hit just past drift window
    clear_arr(); av[0] = 1'b1; sv[5][2] = 1'b1;
    run_ev(4, 3, "R4 hit after window");
    // R3: absorber inside drift window ignored
    clear_arr(); av[0] = 1'b1; av[1] = 1'b1; av[3] = 1'b1; sv[2][5] = 1'b1;
    run_ev(4, 2, "R3 absorber in drift");
    // R5: two channels same cycle
    clear_arr(); av[0] = 1'b1; sv[2][3] = 1'b1; sv[2][9] = 1'b1;
    run_ev(4, 2, "R5 same-cycle multi");
    // R5: same channel twice
    clear_arr(); av[0] = 1'b1; sv[1][6] = 1'b1; sv[3][6] = 1'b1;
    run_ev(4, 2, "R5 repeated channel");
    // R3/R6: zero lengths act as one
    clear_arr(); av[0] = 1'b1; sv[1][0] = 1'b1;
    run_ev(0, 0, "R3 zero lengths");
    // R6: disturbance on last quiet cycle
    clear_arr(); av[0] = 1'b1; sv[1][11] = 1'b1; sv[5][4] = 1'b1;
    run_ev(2, 3, "R6 last quiet cycle");
    // R6: absorber as disturbance
    clear_arr(); av[0] = 1'b1; sv[0][12] = 1'b1; av[3] = 1'b1;
    run_ev(2, 3, "R6 absorber veto");
    // R7: trigger right after quiet window does not purge
    clear_arr(); av[0] = 1'b1; sv[1][13] = 1'b1; sv[6][4] = 1'b1;
    run_ev(2, 3, "R7 after quiet window");

    for (int n = 0; n < 400; n++) begin
      int d, i, dd, ii, mode, j1, j2, c1, c2;
      d = $urandom_range(0, 8); i = $urandom_range(0, 8);
      dd = (d < 1) ? 1 : d; ii = (i < 1) ? 1 : i;
      mode = $urandom_range(0, 2);
      clear_arr(); av[0] = 1'b1;
      if (mode == 0) begin
        if (dd > 1 && $urandom_range(0, 1) == 1) av[$urandom_range(1, dd)] = 1'b1;
        run_ev(d, i, "R4 random zero hits");
      end else if (mode == 1) begin
        j1 = $urandom_range(0, dd); c1 = $urandom_range(0, N - 1);
        sv[j1][c1] = 1'b1;
        if ($urandom_range(0, 2) == 0) av[$urandom_range(1, dd)] = 1'b1;
        if ($urandom_range(0, 1) == 1) begin
          j2 = $urandom_range(dd + 1, dd + ii);
          if ($urandom_range(0, 1) == 1) av[j2] = 1'b1;
          else sv[j2][$urandom_range(0, N - 1)] = 1'b1;
        end
        run_ev(d, i, "R7 random single hit");
      end else begin
        j1 = $urandom_range(0, dd); j2 = $urandom_range(0, dd);
        c1 = $urandom_range(0, N - 1); c2 = (c1 + $urandom_range(1, N - 1)) % N;
        sv[j1][c1] = 1'b1; sv[j2][c2] = 1'b1;
        run_ev(d, i, "R5 random multi hit");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule